// File: doc/BRIEF.md
# Streaming Timestamp Delta Encoder

This block compresses a rising stream of unsigned timestamps. Each sample offered under the input strobe is stored. One cycle later the block emits a tagged word. For the first sample after reset, that word is the raw timestamp. For every later sample, it is the unsigned difference from the previously accepted timestamp.

Each difference is sorted into the narrowest of three width classes (8, 16 or 32 bits). The class is reported as a 2-bit tag, and the value is zero-extended above the class width. A downstream packer can then keep only the significant bytes. When no result is due, all outputs are driven to zero.

Top module: `ts_delta_enc`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `tag_o` and `value_o` are all zero and `valid_i` is ignored.
- R2: A sample is accepted only at a rising clock edge with `rst_ni` high and `valid_i` high. A cycle with `valid_i` low changes no stored state, so the next delta is still taken against the last accepted timestamp.
- R3: The first accepted sample after reset is emitted with tag 2'b10 and `value_o` equal to the timestamp itself.
- R4: Every later sample emits the 32-bit unsigned difference `ts_i - previous`. The stored previous timestamp is replaced on every accepted sample, the first one included.
- R5: A delta from 0 to 255 gives tag 2'b00 with `value_o[31:8]` zero. Equal consecutive timestamps give tag 2'b00 with value 0.
- R6: A delta from 256 to 65535 gives tag 2'b01 with `value_o[31:16]` zero.
- R7: A delta of 65536 or more gives tag 2'b10 with `value_o` carrying the full 32-bit delta.
- R8: Tag 2'b11 is never produced.
- R9: The result for a sample accepted at edge N is valid after edge N+1. Back-to-back accepted samples give back-to-back valid results.
- R10: In any cycle with `valid_o` low, `tag_o` and `value_o` are zero.
- R11: After reset is released, the next accepted sample is again treated as a first sample (R3), even if samples were taken before the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Sample strobe |
| ts_i | input | 32 | Unsigned timestamp |
| valid_o | output | 1 | Result strobe, one cycle after acceptance |
| tag_o | output | 2 | Width class: 00 = 8-bit, 01 = 16-bit, 10 = full |
| value_o | output | 32 | Zero-extended delta or first timestamp |

## Verification
The bench probes the class edges at deltas 255, 256, 65535 and 65536, plus a zero delta. A classifier with an off-by-one threshold or a wrong bit slice would give the wrong tag there, or leave nonzero bits above the class width.

It inserts idle gaps between samples. A design that updates its history on idle cycles would then report a delta against a stale or garbage value.

It also asserts reset in mid-stream with the strobe held high. A design that kept its first-sample flag, or accepted input during reset, would emit a delta where a full timestamp with tag 2'b10 is due.

Finally, it runs back-to-back samples to expose any lost or doubled results under one-cycle latency.

// File: rtl/ts_delta_pkg.sv
package ts_delta_pkg;
  localparam int unsigned TS_W  = 32;
  localparam int unsigned TAG_W = 2;

  typedef enum logic [TAG_W-1:0] {
    TAG_NARROW = 2'b00,
    TAG_MID    = 2'b01,
    TAG_FULL   = 2'b10
  } tag_e;
endpackage

// File: rtl/ts_history.sv
module ts_history #(
  parameter int unsigned TS_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            accept_i,
  input  logic [TS_W-1:0] ts_i,
  output logic [TS_W-1:0] prev_o,
  output logic            have_o
);
  logic [TS_W-1:0] prev_q;
  logic            have_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      have_q <= 1'b0;
    end else if (accept_i) begin
      prev_q <= ts_i;
      have_q <= 1'b1;
    end
  end

  assign prev_o = prev_q;
  assign have_o = have_q;

  // R2
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> $stable(prev_q) && $stable(have_q));
  // R4
  prev_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> prev_q == $past(ts_i) && have_q);
endmodule

// File: rtl/ts_classifier.sv
module ts_classifier
  import ts_delta_pkg::*;
#(
  parameter int unsigned TS_W     = 32,
  parameter int unsigned NARROW_W = 8,
  parameter int unsigned MID_W    = 16
) (
  input  logic [TS_W-1:0] ts_i,
  input  logic [TS_W-1:0] prev_i,
  input  logic            have_i,
  output tag_e            tag_o,
  output logic [TS_W-1:0] value_o
);
  localparam logic [TS_W-1:0] NARROW_MASK = {{(TS_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [TS_W-1:0] MID_MASK    = {{(TS_W-MID_W){1'b0}}, {MID_W{1'b1}}};

  logic [TS_W-1:0] delta;
  logic            fits_narrow, fits_mid;

  assign delta       = ts_i - prev_i;
  assign fits_narrow = ~|delta[TS_W-1:NARROW_W];
  assign fits_mid    = ~|delta[TS_W-1:MID_W];

  always_comb begin
    if (!have_i) begin
      tag_o   = TAG_FULL;
      value_o = ts_i;
    end else if (fits_narrow) begin
      tag_o   = TAG_NARROW;
      value_o = delta & NARROW_MASK;
    end else if (fits_mid) begin
      tag_o   = TAG_MID;
      value_o = delta & MID_MASK;
    end else begin
      tag_o   = TAG_FULL;
      value_o = delta;
    end
  end

  // R5
  narrow_fit_chk: assert final (!(have_i && tag_o == TAG_NARROW) || value_o == ts_i - prev_i);
endmodule

// File: rtl/ts_out_reg.sv
module ts_out_reg
  import ts_delta_pkg::*;
#(
  parameter int unsigned TS_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  tag_e            tag_i,
  input  logic [TS_W-1:0] value_i,
  output logic            valid_o,
  output logic [1:0]      tag_o,
  output logic [TS_W-1:0] value_o
);
  logic            valid_q;
  tag_e            tag_q;
  logic [TS_W-1:0] value_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      tag_q   <= TAG_NARROW;
      value_q <= '0;
    end else begin
      valid_q <= valid_i;
      tag_q   <= valid_i ? tag_i : TAG_NARROW;
      value_q <= valid_i ? value_i : '0;
    end
  end

  assign valid_o = valid_q;
  assign tag_o   = tag_q;
  assign value_o = value_q;

  // R8
  tag_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) tag_o != 2'b11);
  // R10
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> tag_o == 2'b00 && value_o == '0);
  // R9
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_i |=> valid_o);
  // R9
  no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !valid_i |=> !valid_o);
  // R5
  narrow_zext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_o == 2'b00 |-> value_o[TS_W-1:8] == '0);
  // R6
  mid_zext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_o == 2'b01 |-> value_o[TS_W-1:16] == '0 && value_o[15:8] != '0);
endmodule

// File: rtl/ts_delta_enc.sv
module ts_delta_enc
  import ts_delta_pkg::*;
#(
  parameter int unsigned NARROW_W = 8,
  parameter int unsigned MID_W    = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [TS_W-1:0] ts_i,
  output logic            valid_o,
  output logic [1:0]      tag_o,
  output logic [TS_W-1:0] value_o
);
  logic [TS_W-1:0] prev;
  logic            have;
  tag_e            cls_tag;
  logic [TS_W-1:0] cls_value;

  ts_history #(.TS_W(TS_W)) u_hist (
    .clk_i, .rst_ni, .accept_i(valid_i), .ts_i,
    .prev_o(prev), .have_o(have)
  );

  ts_classifier #(.TS_W(TS_W), .NARROW_W(NARROW_W), .MID_W(MID_W)) u_cls (
    .ts_i, .prev_i(prev), .have_i(have),
    .tag_o(cls_tag), .value_o(cls_value)
  );

  ts_out_reg #(.TS_W(TS_W)) u_out (
    .clk_i, .rst_ni, .valid_i, .tag_i(cls_tag), .value_i(cls_value),
    .valid_o, .tag_o, .value_o
  );

  // R3 R11
  first_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !have |=> tag_o == 2'b10 && value_o == $past(ts_i));
endmodule

// File: tb/ts_delta_enc_test.sv
module ts_delta_enc_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] ts_i = '0;
  logic        valid_o;
  logic [1:0]  tag_o;
  logic [31:0] value_o;

  int errors = 0;
  int checks = 0;

  logic [31:0] m_prev = '0;
  logic        m_have = 1'b0;

  ts_delta_enc uut (.*);

  always #5 clk_i = ~clk_i;

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(string req, logic v, logic [1:0] t, logic [31:0] val);
    checks++;
    if (valid_o !== v || tag_o !== t || value_o !== val) begin
      errors++;
      $display("FAIL %s: got v=%0b tag=%b val=%h exp v=%0b tag=%b val=%h",
               req, valid_o, tag_o, value_o, v, t, val);
    end
  endtask

  // drive one sample at negedge, check its result one cycle later
  task automatic send(string req, logic [31:0] ts);
    logic [31:0] d;
    logic [1:0]  t;
    logic [31:0] v;
    valid_i = 1'b1;
    ts_i    = ts;
    if (!m_have) begin t = 2'b10; v = ts; end
    else begin
      d = ts - m_prev;
      if (d <= 32'd255)        begin t = 2'b00; v = d; end
      else if (d <= 32'd65535) begin t = 2'b01; v = d; end
      else                     begin t = 2'b10; v = d; end
    end
    m_prev = ts;
    m_have = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    ts_i    = 32'hDEAD_BEEF;
    chk(req, 1'b1, t, v);
  endtask

  task automatic idle(string req, int n);
    for (int i = 0; i < n; i++) begin
      valid_i = 1'b0;
      ts_i = 32'hFFFF_0000 + i;
      @(negedge clk_i);
      chk(req, 1'b0, 2'b00, 32'h0);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni  = 1'b0;
    valid_i = 1'b1;
    ts_i    = 32'h1234_5678;
    m_have  = 1'b0;
    m_prev  = '0;
    repeat (3) begin
      @(negedge clk_i);
      chk("R1", 1'b0, 2'b00, 32'h0);
    end
    valid_i = 1'b0;
    rst_ni  = 1'b1;
    @(negedge clk_i);
    chk("R1", 1'b0, 2'b00, 32'h0);
  endtask

  task automatic test_first();
    send("R3", 32'h0001_0000);
  endtask

  task automatic test_classes();
    send("R5", 32'h0001_00FF);  // 255
    send("R5", 32'h0001_00FF);  // equal -> 0
    send("R6", 32'h0001_01FF);  // 256
    send("R6", 32'h0002_01FE);  // 65535
    send("R7", 32'h0003_01FE);  // 65536
    send("R7", 32'hF000_0000);  // large
    send("R4", 32'hF000_0007);
  endtask

  task automatic test_gap();
    idle("R10", 3);
    send("R2", 32'hF000_0100);  // delta 249 vs pre-gap sample
  endtask

  task automatic test_reset_midstream();
    send("R9", 32'hF000_0200);
    do_reset();
    send("R11", 32'h0000_0010);
    send("R4", 32'h0000_0020);
  endtask

  initial begin
    @(negedge clk_i);
    chk("R1", 1'b0, 2'b00, 32'h0);
    do_reset();
    test_first();
    test_classes();
    test_gap();
    test_reset_midstream();
    idle("R10", 2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule